// File: doc/BRIEF.md
# System Bus Address Decoder with Boot Overlay

This block sits between a 24-bit, 68000-style processor bus and the memories and peripherals of the system. For each access it gets an address, an access size (byte, word or longword) and a read/write flag. It then asserts exactly one chip select (RAM, ROM or one of ten peripheral windows) or raises a bus-error flag. It also supplies a physical address for the memories and a register offset that is relative to the selected peripheral. In a separate path it folds the per-peripheral service requests into one 3-bit interrupt priority level for the processor.

After reset the processor fetches its initial stack pointer and program counter from addresses 0 and 4. These fetches must come from ROM. A boot overlay state machine has two states, `ST_BOOT` and `ST_RUN`. Reset puts it in `ST_BOOT`. In that state the only accesses allowed are longword reads at 0 and 4, and both are redirected into ROM. Everything else is refused with a bus error. The read at address 4 fires the transition `boot_done` from `ST_BOOT` to `ST_RUN` on the next clock edge. In `ST_RUN` the normal map applies, and the block stays there until the next reset. No other transition exists.

In `ST_RUN`, RAM is decoded first, then ROM, then the peripheral windows in table order. Accesses are checked for size, fit and write protection. Data is big-endian (the lowest address holds the most significant byte), so the decoder passes the start address through unchanged. The memories assemble the bytes.

Top module: `sysbus_decoder`

## Requirements
- R1: Synchronous active-high reset sets `overlay_on`=1 (state `ST_BOOT`). In that state a longword read (`acc_size`=2, `acc_wr`=0) at address 0x000000 asserts `rom_sel` with `phys_addr`=0x100000 and no `bus_err`.
- R2: In `ST_BOOT`, a longword read at 0x000004 asserts `rom_sel` with `phys_addr`=0x100004. From the next clock edge `overlay_on` is 0, and it stays 0 until reset.
- R3: In `ST_BOOT`, any other valid access raises `bus_err` with no chip select and leaves the overlay set. This covers any other address, any other size, and any write.
- R4: In `ST_RUN`, an access of n bytes selects RAM (`ram_sel`, `phys_addr`=address) when address+n-1 ≤ 0x0FFFFF. Size codes are 0=byte (n=1), 1=word (n=2), 2=longword (n=4). Code 3 is illegal and raises `bus_err`.
- R5: In `ST_RUN`, a read of n bytes with 0x100000 ≤ address and address+n-1 ≤ 0x10FFFF asserts `rom_sel` with `phys_addr`=address.
- R6: A write that would hit ROM raises `bus_err` with no chip select.
- R7: A word or longword that starts inside RAM or ROM but runs past its last byte is not given to that region. It falls through to the later checks and raises `bus_err` when nothing else claims it.
- R8: Peripheral window i (bit i of `dev_sel`) is selected when begin ≤ address < end. The windows, in priority order, are given as begin–end (level): 0x180000–0x200000 (0), 0x200000–0x280002 (1), 0x3A0001–0x3A4001 (4), 0x3A4001–0x3A8001 (0), 0x3A8001–0x3AC001 (5), 0x3AC001–0x3B0001 (5), 0x3B0001–0x3B4001 (0), 0x3B4001–0x3B8001 (0), 0x3B8001–0x3BC001 (0), 0x3BC001–0x3C0001 (3).
- R9: `reg_off` is address minus window begin for an even begin, and that difference shifted right by one for an odd begin. It is 0 when no peripheral is selected.
- R10: In `ST_RUN`, a valid access that matches no region raises `bus_err` and asserts no chip select.
- R11: `ipl` is the highest level among windows whose `dev_irq` bit is 1. It is 0 when no bit is set. It does not depend on the access inputs.
- R12: With `acc_valid`=0 there is no chip select and no `bus_err`, and the overlay state is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | 24 | Byte address of the access |
| acc_size | input | 2 | 0 byte, 1 word, 2 longword, 3 illegal |
| acc_wr | input | 1 | 1 write, 0 read |
| dev_irq | input | 10 | Service request, one bit per peripheral window |
| ram_sel | output | 1 | RAM chip select |
| rom_sel | output | 1 | ROM chip select |
| dev_sel | output | 10 | Peripheral chip selects, one-hot or zero |
| phys_addr | output | 24 | Address handed to RAM or ROM, redirected during boot |
| reg_off | output | 24 | Register offset inside the selected peripheral |
| bus_err | output | 1 | Access refused |
| ipl | output | 3 | Interrupt priority level to the processor |
| overlay_on | output | 1 | 1 while in `ST_BOOT` |

## Verification
The bench targets the overlay hand-off. It checks that a read at 0 leaves the overlay in place, and that only a longword read at 4 ends it. A design that cleared the overlay on any fetch, or failed to redirect, would fetch vectors from RAM or lock the map early. It also probes the last legal byte, word and longword of RAM and ROM, plus accesses one byte past them. An off-by-one fit check would select a memory for a straddling access. Finally it walks each window edge, including the odd-based windows whose end is exclusive, and checks the halved offsets. It also checks interrupt mixes in which a lower-numbered window carries a lower level than a later one. A priority encoder that chose by index rather than by level would report the wrong `ipl`.

// File: rtl/sysdec_pkg.sv
package sysdec_pkg;

    localparam int MAP_AW   = 24;
    localparam int MAP_NWIN = 10;
    localparam int LVL_W    = 3;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_BAD  = 2'd3
    } acc_size_e;

    typedef enum logic {
        ST_BOOT = 1'b0,
        ST_RUN  = 1'b1
    } ovl_state_e;

    // Inclusive lower bound of each peripheral window, in priority order.
    function automatic logic [MAP_AW-1:0] win_lo(input int idx);
        case (idx)
            0:       win_lo = 24'h180000;
            1:       win_lo = 24'h200000;
            2:       win_lo = 24'h3A0001;
            3:       win_lo = 24'h3A4001;
            4:       win_lo = 24'h3A8001;
            5:       win_lo = 24'h3AC001;
            6:       win_lo = 24'h3B0001;
            7:       win_lo = 24'h3B4001;
            8:       win_lo = 24'h3B8001;
            9:       win_lo = 24'h3BC001;
            default: win_lo = '1;
        endcase
    endfunction

    // Exclusive upper bound of each peripheral window.
    function automatic logic [MAP_AW-1:0] win_hi(input int idx);
        case (idx)
            0:       win_hi = 24'h200000;
            1:       win_hi = 24'h280002;
            2:       win_hi = 24'h3A4001;
            3:       win_hi = 24'h3A8001;
            4:       win_hi = 24'h3AC001;
            5:       win_hi = 24'h3B0001;
            6:       win_hi = 24'h3B4001;
            7:       win_hi = 24'h3B8001;
            8:       win_hi = 24'h3BC001;
            9:       win_hi = 24'h3C0001;
            default: win_hi = '0;
        endcase
    endfunction

    // Interrupt level that each window raises when it requests service.
    function automatic logic [LVL_W-1:0] win_lvl(input int idx);
        case (idx)
            1:       win_lvl = 3'd1;
            2:       win_lvl = 3'd4;
            4:       win_lvl = 3'd5;
            5:       win_lvl = 3'd5;
            9:       win_lvl = 3'd3;
            default: win_lvl = 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/sysdec_mem_match.sv
module sysdec_mem_match #(
    parameter int          AW    = 24,
    parameter logic [AW:0] BASE  = '0,
    parameter logic [AW:0] BYTES = 1
) (
    input  logic [AW-1:0] addr,
    input  logic [2:0]    nbytes,
    output logic          hit
);
    localparam logic [AW+1:0] LIMIT = {1'b0, BASE} + {1'b0, BYTES};

    logic [AW+1:0] last_excl;

    always_comb begin
        last_excl = {2'b00, addr} + {{(AW-1){1'b0}}, nbytes};
        hit = (nbytes != 3'd0)
           && ({1'b0, addr} >= BASE)
           && (last_excl <= LIMIT);
    end
endmodule

// File: rtl/sysdec_periph_match.sv
module sysdec_periph_match
    import sysdec_pkg::*;
#(
    parameter int AW   = MAP_AW,
    parameter int NWIN = MAP_NWIN
) (
    input  logic [AW-1:0]   addr,
    output logic [NWIN-1:0] sel,
    output logic [AW-1:0]   off
);
    logic [NWIN-1:0] raw_hit;
    logic [AW-1:0]   win_off [NWIN];

    for (genvar g = 0; g < NWIN; g++) begin : g_win
        localparam logic [AW-1:0] LO = AW'(win_lo(g));
        localparam logic [AW-1:0] HI = AW'(win_hi(g));
        logic [AW-1:0] delta;
        assign raw_hit[g] = (addr >= LO) && (addr < HI);
        assign delta      = addr - LO;
        if (LO[0]) begin : g_odd
            assign win_off[g] = delta >> 1;
        end else begin : g_even
            assign win_off[g] = delta;
        end
    end

    // First matching window in table order wins.
    always_comb begin
        logic found;
        found = 1'b0;
        sel   = '0;
        off   = '0;
        for (int i = 0; i < NWIN; i++) begin
            if (raw_hit[i] && !found) begin
                found  = 1'b1;
                sel[i] = 1'b1;
                off    = win_off[i];
            end
        end
    end
endmodule

// File: rtl/sysdec_irq_level.sv
module sysdec_irq_level
    import sysdec_pkg::*;
#(
    parameter int NWIN = MAP_NWIN
) (
    input  logic [NWIN-1:0]  irq,
    output logic [LVL_W-1:0] level
);
    always_comb begin
        level = '0;
        for (int i = 0; i < NWIN; i++) begin
            if (irq[i] && (win_lvl(i) > level)) begin
                level = win_lvl(i);
            end
        end
    end
endmodule

// File: rtl/sysbus_decoder.sv
module sysbus_decoder
    import sysdec_pkg::*;
#(
    parameter int                 ADDR_W    = MAP_AW,
    parameter int                 NDEV      = MAP_NWIN,
    parameter logic [ADDR_W-1:0]  RAM_BASE  = 24'h000000,
    parameter logic [ADDR_W:0]    RAM_BYTES = 25'h100000,
    parameter logic [ADDR_W-1:0]  ROM_BASE  = 24'h100000,
    parameter logic [ADDR_W:0]    ROM_BYTES = 25'h010000,
    parameter logic [ADDR_W-1:0]  VEC_SP    = 24'h000000,
    parameter logic [ADDR_W-1:0]  VEC_PC    = 24'h000004
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        acc_size,
    input  logic              acc_wr,
    input  logic [NDEV-1:0]   dev_irq,
    output logic              ram_sel,
    output logic              rom_sel,
    output logic [NDEV-1:0]   dev_sel,
    output logic [ADDR_W-1:0] phys_addr,
    output logic [ADDR_W-1:0] reg_off,
    output logic              bus_err,
    output logic [LVL_W-1:0]  ipl,
    output logic              overlay_on
);
    ovl_state_e        state_q, state_d;
    acc_size_e         size_e;
    logic [2:0]        nbytes;
    logic              ram_hit, rom_hit;
    logic [NDEV-1:0]   win_sel;
    logic [ADDR_W-1:0] win_off;
    logic              vec_fetch, boot_done;

    assign size_e = acc_size_e'(acc_size);

    always_comb begin
        unique case (size_e)
            SZ_BYTE: nbytes = 3'd1;
            SZ_WORD: nbytes = 3'd2;
            SZ_LONG: nbytes = 3'd4;
            default: nbytes = 3'd0;
        endcase
    end

    sysdec_mem_match #(
        .AW(ADDR_W), .BASE({1'b0, RAM_BASE}), .BYTES(RAM_BYTES)
    ) u_ram_match (
        .addr(acc_addr), .nbytes(nbytes), .hit(ram_hit)
    );

    sysdec_mem_match #(
        .AW(ADDR_W), .BASE({1'b0, ROM_BASE}), .BYTES(ROM_BYTES)
    ) u_rom_match (
        .addr(acc_addr), .nbytes(nbytes), .hit(rom_hit)
    );

    sysdec_periph_match #(
        .AW(ADDR_W), .NWIN(NDEV)
    ) u_periph (
        .addr(acc_addr), .sel(win_sel), .off(win_off)
    );

    sysdec_irq_level #(
        .NWIN(NDEV)
    ) u_irq (
        .irq(dev_irq), .level(ipl)
    );

    assign vec_fetch = acc_valid && !acc_wr && (size_e == SZ_LONG)
                    && ((acc_addr == VEC_SP) || (acc_addr == VEC_PC));
    assign boot_done = vec_fetch && (acc_addr == VEC_PC);

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_BOOT;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BOOT: if (boot_done) state_d = ST_RUN;
            ST_RUN:  state_d = ST_RUN;
            default: state_d = ST_BOOT;
        endcase
    end

    // Outputs
    always_comb begin
        ram_sel    = 1'b0;
        rom_sel    = 1'b0;
        dev_sel    = '0;
        reg_off    = '0;
        bus_err    = 1'b0;
        phys_addr  = acc_addr;
        overlay_on = (state_q == ST_BOOT);
        unique case (state_q)
            ST_BOOT: begin
                if (vec_fetch) begin
                    rom_sel   = 1'b1;
                    phys_addr = ROM_BASE + acc_addr;
                end else if (acc_valid) begin
                    bus_err = 1'b1;
                end
            end
            ST_RUN: begin
                if (acc_valid) begin
                    if (size_e == SZ_BAD) begin
                        bus_err = 1'b1;
                    end else if (ram_hit) begin
                        ram_sel = 1'b1;
                    end else if (rom_hit && !acc_wr) begin
                        rom_sel = 1'b1;
                    end else if (rom_hit) begin
                        bus_err = 1'b1;
                    end else if (|win_sel) begin
                        dev_sel = win_sel;
                        reg_off = win_off;
                    end else begin
                        bus_err = 1'b1;
                    end
                end
            end
            default: bus_err = acc_valid;
        endcase
    end
endmodule

// File: rtl/sysdec_chk.sv
module sysdec_chk #(
    parameter int ADDR_W = 24,
    parameter int NDEV   = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              acc_valid,
    input logic [ADDR_W-1:0] acc_addr,
    input logic [1:0]        acc_size,
    input logic              acc_wr,
    input logic [NDEV-1:0]   dev_irq,
    input logic              ram_sel,
    input logic              rom_sel,
    input logic [NDEV-1:0]   dev_sel,
    input logic              bus_err,
    input logic [2:0]        ipl,
    input logic              overlay_on
);
    // R2: the PC vector fetch ends the overlay on the next edge
    assert_boot_exit_R2: assert property (@(posedge clk) disable iff (rst)
        (overlay_on && acc_valid && !acc_wr && acc_size == 2'd2
         && acc_addr == 24'h000004) |=> !overlay_on);

    // R2: once left, the overlay never comes back without reset
    assert_overlay_sticky_R2: assert property (@(posedge clk) disable iff (rst)
        !overlay_on |=> !overlay_on);

    // R3: refused boot accesses keep the overlay
    assert_boot_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (overlay_on && bus_err) |=> overlay_on);

    // R8: at most one chip select
    assert_sel_onehot_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ram_sel, rom_sel, dev_sel}));

    // R10: an error never comes with a select
    assert_err_nosel_R10: assert property (@(posedge clk) disable iff (rst)
        bus_err |-> !(ram_sel || rom_sel || |dev_sel));

    // R6: ROM is never selected for a write
    assert_rom_nowrite_R6: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_wr) |-> !rom_sel);

    // R12: idle bus is quiet
    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |-> !(bus_err || ram_sel || rom_sel || |dev_sel));

    // R11: no request, no level
    assert_ipl_zero_R11: assert property (@(posedge clk) disable iff (rst)
        (dev_irq == '0) |-> (ipl == 3'd0));
endmodule

bind sysbus_decoder sysdec_chk #(.ADDR_W(ADDR_W), .NDEV(NDEV)) u_chk (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_size(acc_size), .acc_wr(acc_wr), .dev_irq(dev_irq),
    .ram_sel(ram_sel), .rom_sel(rom_sel), .dev_sel(dev_sel),
    .bus_err(bus_err), .ipl(ipl), .overlay_on(overlay_on)
);

// File: tb/sysbus_decoder_tb.sv
module sysbus_decoder_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_valid = 1'b0;
    logic [23:0] acc_addr = '0;
    logic [1:0]  acc_size = '0;
    logic        acc_wr = 1'b0;
    logic [9:0]  dev_irq = '0;
    logic        ram_sel, rom_sel, bus_err, overlay_on;
    logic [9:0]  dev_sel;
    logic [23:0] phys_addr, reg_off;
    logic [2:0]  ipl;

    int n_chk = 0;
    int n_bad = 0;
    bit m_boot = 1'b1;
    bit done = 1'b0;

    localparam logic [23:0] TLO [10] = '{24'h180000, 24'h200000, 24'h3A0001,
        24'h3A4001, 24'h3A8001, 24'h3AC001, 24'h3B0001, 24'h3B4001,
        24'h3B8001, 24'h3BC001};
    localparam logic [23:0] THI [10] = '{24'h200000, 24'h280002, 24'h3A4001,
        24'h3A8001, 24'h3AC001, 24'h3B0001, 24'h3B4001, 24'h3B8001,
        24'h3BC001, 24'h3C0001};
    localparam logic [2:0] TLV [10] = '{3'd0, 3'd1, 3'd4, 3'd0, 3'd5, 3'd5,
        3'd0, 3'd0, 3'd0, 3'd3};

    sysbus_decoder dut_i (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_size(acc_size), .acc_wr(acc_wr), .dev_irq(dev_irq),
        .ram_sel(ram_sel), .rom_sel(rom_sel), .dev_sel(dev_sel),
        .phys_addr(phys_addr), .reg_off(reg_off), .bus_err(bus_err),
        .ipl(ipl), .overlay_on(overlay_on)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h (addr %h size %0d wr %0b)",
                     req, got, exp, acc_addr, acc_size, acc_wr);
        end
    endtask

    function automatic logic [2:0] ref_ipl(input logic [9:0] irq);
        logic [2:0] l = 0;
        for (int i = 0; i < 10; i++) if (irq[i] && TLV[i] > l) l = TLV[i];
        return l;
    endfunction

    // Applies one access, compares all outputs against the reference model,
    // then lets the clock edge advance the overlay model.
    task automatic apply(input bit v, input logic [23:0] a, input logic [1:0] sz,
                         input bit w, input string req);
        int n;
        bit e_ram, e_rom, e_err;
        logic [9:0] e_dev;
        logic [23:0] e_off, e_phys;
        @(negedge clk);
        acc_valid = v; acc_addr = a; acc_size = sz; acc_wr = w;
        dev_irq = 10'($urandom);
        n = (sz == 0) ? 1 : (sz == 1) ? 2 : (sz == 2) ? 4 : 0;
        e_ram = 0; e_rom = 0; e_err = 0; e_dev = 0; e_off = 0; e_phys = a;
        if (v && m_boot) begin
            if (!w && sz == 2 && (a == 0 || a == 4)) begin
                e_rom = 1; e_phys = 24'h100000 + a;
            end else e_err = 1;
        end else if (v) begin
            if (n == 0) e_err = 1;
            else if (32'(a) + n - 1 <= 32'h0FFFFF) e_ram = 1;
            else if (a >= 24'h100000 && 32'(a) + n - 1 <= 32'h10FFFF) begin
                if (w) e_err = 1; else e_rom = 1;
            end else begin
                e_err = 1;
                for (int i = 0; i < 10; i++) begin
                    if (e_err && a >= TLO[i] && a < THI[i]) begin
                        e_err = 0; e_dev[i] = 1;
                        e_off = TLO[i][0] ? (a - TLO[i]) >> 1 : a - TLO[i];
                    end
                end
            end
        end
        #2;
        chk({req, " ram_sel"}, 32'(ram_sel), 32'(e_ram));
        chk({req, " rom_sel"}, 32'(rom_sel), 32'(e_rom));
        chk({req, " dev_sel"}, 32'(dev_sel), 32'(e_dev));
        chk({req, " bus_err"}, 32'(bus_err), 32'(e_err));
        chk({req, " reg_off R9"}, 32'(reg_off), 32'(e_off));
        if (e_ram || e_rom) chk({req, " phys_addr"}, 32'(phys_addr), 32'(e_phys));
        chk({req, " overlay_on"}, 32'(overlay_on), 32'(m_boot));
        chk("R11 ipl", 32'(ipl), 32'(ref_ipl(dev_irq)));
        @(posedge clk);
        if (m_boot && v && !w && sz == 2 && a == 4) m_boot = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; acc_valid = 0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst = 0; m_boot = 1;
        #2 chk("R1 reset overlay_on", 32'(overlay_on), 32'd1);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        // Boot sequence with refused accesses in between
        apply(0, 24'h000000, 2, 0, "R12 idle in boot");
        apply(1, 24'h000000, 2, 0, "R1 SP fetch");
        apply(1, 24'h000000, 2, 0, "R1 SP fetch repeat");
        apply(1, 24'h000004, 1, 0, "R3 word at PC vector");
        apply(1, 24'h000004, 2, 1, "R3 write at PC vector");
        apply(1, 24'h000008, 2, 0, "R3 other address");
        apply(1, 24'h100000, 0, 0, "R3 ROM byte in boot");
        apply(1, 24'h000004, 2, 0, "R2 PC fetch");
        apply(1, 24'h000000, 2, 0, "R2 after boot RAM read");
        apply(1, 24'h000004, 2, 0, "R2 overlay stays off");
        // Memory edges
        for (int s = 0; s < 3; s++) begin
            automatic logic [23:0] n = 24'(1 << s);
            apply(1, 24'h100000 - n, 2'(s), 1, "R4 RAM last unit write");
            apply(1, 24'h100000 - n + 1, 2'(s), 0, "R7 RAM straddle");
            apply(1, 24'h100000, 2'(s), 0, "R5 ROM first read");
            apply(1, 24'h110000 - n, 2'(s), 0, "R5 ROM last read");
            apply(1, 24'h110000 - n + 1, 2'(s), 0, "R7 ROM straddle");
            apply(1, 24'h108000, 2'(s), 1, "R6 ROM write");
        end
        apply(1, 24'h000010, 3, 0, "R4 illegal size");
        apply(1, 24'h150000, 0, 0, "R10 hole");
        apply(1, 24'h3C0001, 0, 0, "R10 past last window");
        apply(0, 24'h3A0001, 0, 0, "R12 idle in run");
        // Window edges
        for (int i = 0; i < 10; i++) begin
            apply(1, TLO[i], 1, 0, "R8 window begin");
            apply(1, TLO[i] + 24'd7, 0, 1, "R9 window offset");
            apply(1, THI[i] - 24'd1, 0, 0, "R8 window last");
            apply(1, TLO[i] - 24'd1, 0, 0, "R8 below window");
        end
        apply(1, 24'h280002, 0, 0, "R10 end of window 1");
        // Random accesses biased toward region edges
        for (int k = 0; k < 1500; k++) begin
            automatic int pick = $urandom_range(0, 3);
            automatic logic [23:0] a;
            if (pick == 0) a = 24'($urandom_range(0, 24'h3FFFFF));
            else if (pick == 1) a = 24'h100000 + 24'($urandom_range(0, 16)) - 24'd8;
            else if (pick == 2) a = 24'h110000 + 24'($urandom_range(0, 16)) - 24'd8;
            else begin
                automatic int w = $urandom_range(0, 9);
                a = (($urandom_range(0, 1) == 0) ? TLO[w] : THI[w])
                    + 24'($urandom_range(0, 8)) - 24'd4;
            end
            apply($urandom_range(0, 7) != 0, a, 2'($urandom_range(0, 3)),
                  1'($urandom_range(0, 1)), "R4 R5 R8 random");
        end
        // Second reset: overlay returns
        do_reset();
        apply(1, 24'h000020, 0, 1, "R3 write after reset");
        apply(1, 24'h000004, 2, 0, "R2 PC fetch after reset");
        apply(1, 24'h000020, 0, 1, "R4 RAM write after boot");
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule